// File: doc/BRIEF.md
# Fail-Safe Differential Bus Transceiver Controller

This block holds the logic-level decisions of a half- or full-duplex differential line transceiver. It combines the driver enable, the receiver enable, a sampled bus differential voltage, an open-line flag, the die temperature and two supply-good flags. From these it sets the levels and enables of the two driver outputs and the receive-data output. The analog front end turns these levels and enables into bus voltages and three-state pins.

The receiver uses a threshold that lies wholly below zero, so an idle bus at 0 V or a disconnected line reads as a logic high. Inputs inside the band between the two thresholds keep the last resolved level. The driver shuts off during an over-temperature event and turns back on only after the die has cooled by a set margin. It also shuts off when either supply fails. The receive output takes fixed defaults when a supply fails. Every output is registered on one clock.

Top module: `rs485_failsafe_ctrl`

## Requirements
- R1: When the driver is enabled, both supplies are good and no thermal shutdown is active, y_oe and z_oe are 1, y_lvl equals tx_data and z_lvl is its inverse.
- R2: When drv_en is 0, y_oe and z_oe are 0 and y_lvl and z_lvl are 0.
- R3: With logic_pwr_ok at 1 and rcv_en_n at 1, rx_oe is 0 and rx_lvl is 0.
- R4: With both supplies good, the receiver enabled and bus_open at 0, a diff_mv greater than -30 gives rx_lvl 1 and a diff_mv less than -200 gives rx_lvl 0, with rx_oe at 1.
- R5: With both supplies good and the receiver enabled, bus_open at 1 gives rx_lvl 1 whatever the value of diff_mv.
- R6: A diff_mv from -200 to -30 inclusive keeps the last resolved receive level. After reset that level is 1.
- R7: Thermal shutdown turns on when temp_c is 150 or more. It turns off only when temp_c is 140 or less. Between those values it keeps its state, and while it is on the driver outputs are disabled.
- R8: If either logic_pwr_ok or bus_pwr_ok is 0, y_oe and z_oe are 0, whatever the enable and data inputs.
- R9: With logic_pwr_ok at 1, bus_pwr_ok at 0 and rcv_en_n at 0, rx_oe is 1 and rx_lvl is 1. With logic_pwr_ok at 0, rx_oe is 1 and rx_lvl is 0, whatever rcv_en_n is.
- R10: While rst_n is 0, every output is 0 and thermal shutdown is cleared.
- R11: Every output reflects the inputs present at the rising clock edge that follows them, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | 1 | Data to transmit |
| drv_en | input | 1 | Driver enable, active high |
| rcv_en_n | input | 1 | Receiver enable, active low |
| diff_mv | input | 16 | Signed bus differential voltage in millivolts |
| bus_open | input | 1 | Receiver inputs open or shorted |
| temp_c | input | 10 | Signed die temperature in degrees Celsius |
| logic_pwr_ok | input | 1 | Logic-side supply good |
| bus_pwr_ok | input | 1 | Bus-side supply good |
| y_lvl | output | 1 | Level of the non-inverting driver output |
| y_oe | output | 1 | Enable of the non-inverting driver output |
| z_lvl | output | 1 | Level of the inverting driver output |
| z_oe | output | 1 | Enable of the inverting driver output |
| rx_lvl | output | 1 | Receive-data level |
| rx_oe | output | 1 | Receive-data enable |

## Verification
Every result, whether a driver level, an enable, a receive level or the effect of a thermal transition, is due at the first rising edge after its inputs are applied. The bench changes inputs on the falling edge. It updates its reference model of the thermal state and the held receive level at the rising edge, and compares the outputs at the next falling edge. Directed cases cover both threshold boundaries and the hold band. They also step the temperature across the trip and clear points to show the hysteresis, and go through each supply-loss combination. Seeded random cycles then mix all the inputs together.

// File: rtl/rs485_failsafe_ctrl.sv
module rs485_failsafe_ctrl #(
  parameter int DIFF_W   = 16,
  parameter int TEMP_W   = 10,
  parameter int RX_HI_MV = -30,
  parameter int RX_LO_MV = -200,
  parameter int TRIP_C   = 150,
  parameter int CLEAR_C  = 140
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tx_data,
  input  logic                     drv_en,
  input  logic                     rcv_en_n,
  input  logic signed [DIFF_W-1:0] diff_mv,
  input  logic                     bus_open,
  input  logic signed [TEMP_W-1:0] temp_c,
  input  logic                     logic_pwr_ok,
  input  logic                     bus_pwr_ok,
  output logic                     y_lvl,
  output logic                     y_oe,
  output logic                     z_lvl,
  output logic                     z_oe,
  output logic                     rx_lvl,
  output logic                     rx_oe
);

  localparam logic signed [DIFF_W-1:0] HI_T  = DIFF_W'(RX_HI_MV);
  localparam logic signed [DIFF_W-1:0] LO_T  = DIFF_W'(RX_LO_MV);
  localparam logic signed [TEMP_W-1:0] TRIP_T = TEMP_W'(TRIP_C);
  localparam logic signed [TEMP_W-1:0] CLR_T  = TEMP_W'(CLEAR_C);

  logic hot_q, dec_q;
  logic sup_ok, hot_d, drive, above_hi, below_lo, dec_d;
  logic rx_oe_d, rx_lvl_d;

  assign sup_ok   = logic_pwr_ok & bus_pwr_ok;
  assign hot_d    = (temp_c >= TRIP_T) ? 1'b1 :
                    (temp_c <= CLR_T)  ? 1'b0 : hot_q;
  assign drive    = drv_en & sup_ok & ~hot_d;

  assign above_hi = bus_open | (diff_mv > HI_T);
  assign below_lo = ~bus_open & (diff_mv < LO_T);
  assign dec_d    = !sup_ok  ? dec_q :
                    above_hi ? 1'b1  :
                    below_lo ? 1'b0  : dec_q;

  always_comb begin
    if (!logic_pwr_ok) begin
      rx_oe_d  = 1'b1;
      rx_lvl_d = 1'b0;
    end else if (rcv_en_n) begin
      rx_oe_d  = 1'b0;
      rx_lvl_d = 1'b0;
    end else if (!bus_pwr_ok) begin
      rx_oe_d  = 1'b1;
      rx_lvl_d = 1'b1;
    end else begin
      rx_oe_d  = 1'b1;
      rx_lvl_d = dec_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hot_q  <= 1'b0;
      dec_q  <= 1'b1;
      y_oe   <= 1'b0;
      z_oe   <= 1'b0;
      y_lvl  <= 1'b0;
      z_lvl  <= 1'b0;
      rx_oe  <= 1'b0;
      rx_lvl <= 1'b0;
    end else begin
      hot_q  <= hot_d;
      dec_q  <= dec_d;
      y_oe   <= drive;
      z_oe   <= drive;
      y_lvl  <= drive & tx_data;
      z_lvl  <= drive & ~tx_data;
      rx_oe  <= rx_oe_d;
      rx_lvl <= rx_lvl_d;
    end
  end

  assert_drv_complement_R1: assert property (@(posedge clk) disable iff (!rst_n)
    y_oe |-> (z_oe && (z_lvl == !y_lvl)));
  assert_drv_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |=> (!y_oe && !z_oe && !y_lvl && !z_lvl));
  assert_rx_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (logic_pwr_ok && rcv_en_n) |=> (!rx_oe && !rx_lvl));
  assert_rx_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_ok && !rcv_en_n && !bus_open && (diff_mv < LO_T)) |=> (rx_oe && !rx_lvl));
  assert_rx_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_ok && !rcv_en_n && bus_open) |=> (rx_oe && rx_lvl));
  assert_thermal_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_c >= TRIP_T) |=> (!y_oe && !z_oe));
  assert_supply_drv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_ok |=> (!y_oe && !z_oe));
  assert_logic_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !logic_pwr_ok |=> (rx_oe && !rx_lvl));

endmodule

// File: tb/rs485_failsafe_ctrl_tb.sv
module rs485_failsafe_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_data = 0, drv_en = 0, rcv_en_n = 1, bus_open = 0;
  logic logic_pwr_ok = 1, bus_pwr_ok = 1;
  logic signed [15:0] diff_mv = '0;
  logic signed [9:0]  temp_c = 10'sd25;
  logic y_lvl, y_oe, z_lvl, z_oe, rx_lvl, rx_oe;

  int total = 0;
  int bad = 0;
  bit hot_m = 0;
  bit dec_m = 1;
  logic [5:0] exp_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs485_failsafe_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .drv_en(drv_en),
    .rcv_en_n(rcv_en_n), .diff_mv(diff_mv), .bus_open(bus_open),
    .temp_c(temp_c), .logic_pwr_ok(logic_pwr_ok), .bus_pwr_ok(bus_pwr_ok),
    .y_lvl(y_lvl), .y_oe(y_oe), .z_lvl(z_lvl), .z_oe(z_oe),
    .rx_lvl(rx_lvl), .rx_oe(rx_oe));

  // reference: {y_oe, z_oe, y_lvl, z_lvl, rx_oe, rx_lvl}
  function automatic logic [5:0] model_next(input bit hot_n, input bit dec_n);
    bit drive;
    bit roe, rlv;
    drive = drv_en && logic_pwr_ok && bus_pwr_ok && !hot_n;
    if (!logic_pwr_ok)   begin roe = 1; rlv = 0; end
    else if (rcv_en_n)   begin roe = 0; rlv = 0; end
    else if (!bus_pwr_ok) begin roe = 1; rlv = 1; end
    else                 begin roe = 1; rlv = dec_n; end
    return {drive, drive, drive && tx_data, drive && !tx_data, roe, rlv};
  endfunction

  task automatic compare(input string tag);
    logic [5:0] act;
    act = {y_oe, z_oe, y_lvl, z_lvl, rx_oe, rx_lvl};
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp_v);
    end
  endtask

  task automatic step(input string tag);
    bit hot_n, dec_n;
    @(posedge clk);
    hot_n = (temp_c >= 150) ? 1'b1 : (temp_c <= 140) ? 1'b0 : hot_m;
    dec_n = dec_m;
    if (logic_pwr_ok && bus_pwr_ok) begin
      if (bus_open || diff_mv > -30) dec_n = 1;
      else if (diff_mv < -200)       dec_n = 0;
    end
    exp_v = model_next(hot_n, dec_n);
    hot_m = hot_n;
    dec_m = dec_n;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    bad++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    exp_v = 6'b0;
    compare("R10");
    rst_n = 1'b1;
    hot_m = 0; dec_m = 1;

    drv_en = 1; tx_data = 1; rcv_en_n = 0; diff_mv = 0;  step("R1");
    tx_data = 0;                                        step("R1");
    drv_en = 0;                                         step("R2");
    rcv_en_n = 1;                                       step("R3");
    rcv_en_n = 0; diff_mv = -201;                       step("R4");
    diff_mv = -30;                                      step("R6");
    diff_mv = -29;                                      step("R4");
    diff_mv = -200;                                     step("R6");
    diff_mv = -500; bus_open = 1;                       step("R5");
    bus_open = 0;                                       step("R4");
    diff_mv = 0;                                        step("R4");
    drv_en = 1; tx_data = 1; temp_c = 150;              step("R7");
    temp_c = 145;                                       step("R7");
    temp_c = 141;                                       step("R7");
    temp_c = 140;                                       step("R7");
    temp_c = 149;                                       step("R7");
    bus_pwr_ok = 0;                                     step("R8");
    diff_mv = -500;                                     step("R9");
    logic_pwr_ok = 0; rcv_en_n = 1;                     step("R9");
    bus_pwr_ok = 1; rcv_en_n = 0;                       step("R8");
    logic_pwr_ok = 1; diff_mv = -100;                   step("R6");
    temp_c = 25;

    for (int i = 0; i < 3000; i++) begin
      tx_data      = $urandom_range(1, 0);
      drv_en       = $urandom_range(1, 0);
      rcv_en_n     = ($urandom_range(3, 0) == 0);
      bus_open     = ($urandom_range(9, 0) == 0);
      diff_mv      = 16'($signed($urandom_range(600, 0)) - 400);
      temp_c       = 10'($urandom_range(160, 130));
      logic_pwr_ok = ($urandom_range(15, 0) != 0);
      bus_pwr_ok   = ($urandom_range(15, 0) != 0);
      step("R11");
    end
    summary();
  end
endmodule